// File: doc/BRIEF.md
# Timer Input Capture Unit

This unit timestamps transitions on a single input pin. The pin is brought into the clock domain by a two-flop synchroniser, and an edge detector follows it. A mode filter then decides which edges count as capture events. On each capture event the unit stores the value of a chosen free-running timer in a four-entry FIFO. Software pops the stored values one at a time through a read port.

The timer value comes from one of two 16-bit timers, or from the two timers cascaded as one 32-bit count. An interrupt pulse is raised after every 1 to 4 capture events, and the number is programmable. A stop-in-idle option stops capturing while the idle input is high. A control register at address 0 and a status register at address 1 sit on a simple write-strobe register bus. The register read data is combinational on the address.

Top module: `tcap_top`

## Requirements
- R1: While the enable bit (control bit 0) is 0, the FIFO is flushed, the overflow flag is cleared, the interrupt event counter is cleared, and irq_o stays low. After re-enabling, the interrupt count starts again from zero.
- R2: The control register sits at address 0. Its fields are: bit 0 enable, bits 3:1 mode, bit 4 first-edge-rising, bits 6:5 interrupt divisor, bit 7 timer-A select, bit 8 wide, bit 9 halt-in-idle. It resets to 0. The status register sits at address 1, with bit 0 buffer-not-empty and bit 1 overflow. Both read 0 after reset.
- R3: A pin level applied before clock edge k is captured at edge k+2. The value stored is the timer value present in the cycle that ends at edge k+2, and buffer-not-empty reads 1 after edge k+2.
- R4: Mode 001 captures every edge, mode 010 captures every falling edge, and mode 011 captures every rising edge.
- R5: Mode 100 captures every 4th rising edge and mode 101 captures every 16th rising edge. The count starts again on any write to the control register.
- R6: Mode 110 captures every edge, alternating between edge types. The first edge captured is a rising edge when first-edge-rising is 1 and a falling edge when it is 0; edges of the other type are skipped until that first capture. Modes 000 and 111 capture nothing.
- R7: With wide=1 the stored value is {tmr_b_i, tmr_a_i}, and the timer-A select bit has no effect. With wide=0 the stored value is tmr_a_i zero-extended when timer-A select is 1, and tmr_b_i zero-extended when it is 0.
- R8: The FIFO holds 4 entries. cap_data_o shows the oldest entry, and a cycle with cap_rd_i high pops one entry.
- R9: A capture event while the FIFO is full is discarded and sets the overflow flag. The stored entries are kept, and the flag stays set until the FIFO has been emptied by reads.
- R10: irq_o is a one-cycle pulse after every (divisor+1)-th capture event. Divisor 00 gives a pulse on every event, 01 on every 2nd, 10 on every 3rd and 11 on every 4th. Discarded events also count.
- R11: With halt-in-idle set and idle_i high, no edge is captured. With halt-in-idle clear, capture goes on while idle_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| cap_rd_i | input | 1 | Pop the oldest captured value |
| cap_data_o | output | 32 | Oldest captured value |
| pin_i | input | 1 | Asynchronous capture pin |
| tmr_a_i | input | 16 | Timer A count, low half of the cascaded pair |
| tmr_b_i | input | 16 | Timer B count, high half of the cascaded pair |
| idle_i | input | 1 | Idle indication |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest state to reach is overflow: a fifth capture arrives while four entries wait, is discarded, and the flag has to survive three further pops. The scoreboard monitor normally drains the FIFO as soon as it fills, so it is paused for this part. The bench then makes five edges with distinct timer values and pops the entries by hand. After each pop it checks the head value and the flag, and it shows that the fifth value never appears. The 16th-rising-edge mode and the restart of the edge prescaler on a control write are also driven at length, because both need long runs of edges before anything is captured.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [2:0] {
    MODE_OFF    = 3'b000,
    MODE_ANY    = 3'b001,
    MODE_FALL   = 3'b010,
    MODE_RISE   = 3'b011,
    MODE_RISE_A = 3'b100,
    MODE_RISE_B = 3'b101,
    MODE_ALT    = 3'b110,
    MODE_RSV    = 3'b111
  } cap_mode_e;

  // bit 0 en, 3:1 mode, 4 first_rise, 6:5 irq_div, 7 sel_a, 8 wide, 9 halt_idle
  typedef struct packed {
    logic      halt_idle;
    logic      wide;
    logic      sel_a;
    logic [1:0] irq_div;
    logic      first_rise;
    cap_mode_e mode;
    logic      en;
  } cap_ctrl_t;

  localparam int CTRL_W = $bits(cap_ctrl_t);
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= lvl;
    end
  end

  assign rise_o = lvl & ~last_q;
  assign fall_o = ~lvl & last_q;
endmodule

// File: rtl/tcap_evt.sv
module tcap_evt
  import tcap_pkg::*;
#(
  parameter int PRE_A = 4,
  parameter int PRE_B = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      run_i,
  input  cap_mode_e mode_i,
  input  logic      first_rise_i,
  input  logic      rise_i,
  input  logic      fall_i,
  output logic      evt_o
);
  localparam int PW = $clog2(PRE_B);

  logic [PW-1:0] pre_q;
  logic          armed_q;
  logic          next_rise_q;
  logic          want_rise;
  logic          hit_a;
  logic          hit_b;
  logic          pre_mode;
  logic          raw_evt;

  // before the first alternate capture the live first-edge bit decides
  assign want_rise = armed_q ? next_rise_q : first_rise_i;
  assign hit_a     = (pre_q == PW'(PRE_A - 1));
  assign hit_b     = (pre_q == PW'(PRE_B - 1));
  assign pre_mode  = (mode_i == MODE_RISE_A) || (mode_i == MODE_RISE_B);

  always_comb begin
    unique case (mode_i)
      MODE_ANY:    raw_evt = rise_i | fall_i;
      MODE_FALL:   raw_evt = fall_i;
      MODE_RISE:   raw_evt = rise_i;
      MODE_RISE_A: raw_evt = rise_i & hit_a;
      MODE_RISE_B: raw_evt = rise_i & hit_b;
      MODE_ALT:    raw_evt = want_rise ? rise_i : fall_i;
      default:     raw_evt = 1'b0;
    endcase
  end

  assign evt_o = run_i & raw_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q       <= '0;
      armed_q     <= 1'b0;
      next_rise_q <= 1'b0;
    end else if (clr_i) begin
      pre_q       <= '0;
      armed_q     <= 1'b0;
      next_rise_q <= 1'b0;
    end else if (run_i) begin
      if (rise_i && pre_mode) begin
        if ((mode_i == MODE_RISE_A && hit_a) || (mode_i == MODE_RISE_B && hit_b))
          pre_q <= '0;
        else
          pre_q <= pre_q + 1'b1;
      end
      if (mode_i == MODE_ALT && evt_o) begin
        armed_q     <= 1'b1;
        next_rise_q <= ~want_rise;
      end
    end
  end
endmodule

// File: rtl/tcap_fifo.sv
module tcap_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         push_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         empty_o,
  output logic                         ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full;
  logic          push_ok, pop_ok;
  logic          ovf_q;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full;
  assign pop_ok  = pop_i & ~empty_o;
  assign cnt_d   = cnt_q + CW'(push_ok) - CW'(pop_ok);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (push_ok) wptr_q <= ptr_inc(wptr_q);
      if (pop_ok)  rptr_q <= ptr_inc(rptr_q);
      cnt_q <= cnt_d;
      if (push_i && full)  ovf_q <= 1'b1;
      else if (cnt_d == '0) ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/tcap_irq.sv
module tcap_irq #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             evt_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             irq_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (evt_i) begin
        if (cnt_q >= div_i) begin
          cnt_q <= '0;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tcap_top.sv
module tcap_top
  import tcap_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_A       = 4,
  parameter int PRE_B       = 16,
  parameter int REG_W       = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic               reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               cap_rd_i,
  output logic [2*TMR_W-1:0] cap_data_o,
  input  logic               pin_i,
  input  logic [TMR_W-1:0]   tmr_a_i,
  input  logic [TMR_W-1:0]   tmr_b_i,
  input  logic               idle_i,
  output logic               irq_o
);
  localparam int CAP_W = 2 * TMR_W;
  localparam int CW    = $clog2(DEPTH + 1);

  cap_ctrl_t      ctrl_q;
  logic           ctrl_wr;
  logic           ctrl_en;
  logic           halt_now;
  logic           run;
  logic           pin_rise, pin_fall;
  logic           cap_evt;
  logic [CAP_W-1:0] cap_src;
  logic [CW-1:0]  fifo_cnt;
  logic           fifo_empty;
  logic           ovf_flag;
  logic           irq_raw;
  logic           unused_wdata;

  assign unused_wdata = ^reg_wdata_i[REG_W-1:CTRL_W];

  assign ctrl_wr  = reg_we_i & ~reg_addr_i;
  assign ctrl_en  = ctrl_q.en;
  assign halt_now = ctrl_q.halt_idle & idle_i;
  assign run      = ctrl_en & ~halt_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= cap_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  end

  always_comb begin
    reg_rdata_o = '0;
    if (!reg_addr_i) begin
      reg_rdata_o[CTRL_W-1:0] = ctrl_q;
    end else begin
      reg_rdata_o[0] = ~fifo_empty;
      reg_rdata_o[1] = ovf_flag;
    end
  end

  tcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  tcap_evt #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_evt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (ctrl_wr | ~ctrl_en),
    .run_i        (run),
    .mode_i       (ctrl_q.mode),
    .first_rise_i (ctrl_q.first_rise),
    .rise_i       (pin_rise),
    .fall_i       (pin_fall),
    .evt_o        (cap_evt)
  );

  always_comb begin
    if (ctrl_q.wide)       cap_src = {tmr_b_i, tmr_a_i};
    else if (ctrl_q.sel_a) cap_src = {{TMR_W{1'b0}}, tmr_a_i};
    else                   cap_src = {{TMR_W{1'b0}}, tmr_b_i};
  end

  tcap_fifo #(.DW(CAP_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (~ctrl_en),
    .push_i  (cap_evt),
    .wdata_i (cap_src),
    .pop_i   (cap_rd_i),
    .rdata_o (cap_data_o),
    .count_o (fifo_cnt),
    .empty_o (fifo_empty),
    .ovf_o   (ovf_flag)
  );

  tcap_irq #(.DIV_W(2)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~ctrl_en),
    .evt_i  (cap_evt),
    .div_i  (ctrl_q.irq_div),
    .irq_o  (irq_raw)
  );

  assign irq_o = irq_raw & ctrl_en;
endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       ctrl_en,
  input logic                       halt_now,
  input logic                       cap_rd_i,
  input logic                       reg_we_i,
  input logic                       cap_evt,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic                       ovf_flag,
  input logic                       irq_o
);
  AST_DIS_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en |-> !irq_o); // R1
  AST_DIS_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en |=> fifo_cnt == '0); // R1
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= DEPTH); // R8
  AST_OVF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_flag |-> fifo_cnt != '0); // R9
  AST_OVF_FROM_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag) |-> $past(fifo_cnt) == DEPTH); // R9
  AST_IRQ_AFTER_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(cap_evt)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_en && halt_now && !cap_rd_i && !reg_we_i) |=> $stable(fifo_cnt)); // R11
endmodule

bind tcap_top tcap_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ctrl_en  (ctrl_en),
  .halt_now (halt_now),
  .cap_rd_i (cap_rd_i),
  .reg_we_i (reg_we_i),
  .cap_evt  (cap_evt),
  .fifo_cnt (fifo_cnt),
  .ovf_flag (ovf_flag),
  .irq_o    (irq_o)
);

// File: tb/sim_tcap_top.sv
module sim_tcap_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b1;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cap_rd;
  logic [31:0] cap_data;
  logic        pin = 1'b0;
  logic [15:0] tmr_a = '0, tmr_b = '0;
  logic        idle = 1'b0;
  logic        irq;

  always #10 clk = ~clk;

  tcap_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .cap_rd_i(cap_rd),
    .cap_data_o(cap_data), .pin_i(pin), .tmr_a_i(tmr_a), .tmr_b_i(tmr_b),
    .idle_i(idle), .irq_o(irq)
  );

  int total = 0, bad = 0;
  int irq_n = 0, irq_wide = 0;
  logic irq_prev = 1'b0;
  logic [31:0] q[$];
  logic mon_on = 1'b0, mon_rd = 1'b0, man_rd = 1'b0;
  bit cur_wide = 0, cur_sel = 0;
  logic [15:0] seq = '0;
  logic [31:0] last_exp;
  bit done = 0;

  assign cap_rd = mon_rd | man_rd;

  task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops whatever the design captured and compares
  always begin
    @(negedge clk); #1;
    if (mon_rd) mon_rd = 1'b0;
    else if (mon_on && reg_addr && reg_rdata[0]) begin
      if (q.size() == 0) chk_eq("R4 unexpected capture", cap_data, 32'hx);
      else chk_eq("R7 captured value", cap_data, q.pop_front());
      mon_rd = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (irq) irq_n++;
    if (irq && irq_prev) irq_wide++;
    irq_prev = irq;
  end

  function automatic logic [31:0] cw(bit en, logic [2:0] mode, bit first, logic [1:0] div,
                                     bit sel, bit wide, bit halt);
    return {22'd0, halt, wide, sel, div, first, mode, en};
  endfunction

  task automatic wr_ctrl(logic [31:0] v);
    @(negedge clk); reg_addr = 1'b0; reg_wdata = v; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0; reg_addr = 1'b1;
    cur_wide = v[8]; cur_sel = v[7];
  endtask

  task automatic cfg(logic [31:0] v);
    wr_ctrl(32'd0);
    wr_ctrl(v);
  endtask

  task automatic pin_to(bit lvl, bit cap);
    seq++;
    tmr_a = 16'h1000 + seq;
    tmr_b = 16'h8000 ^ (seq * 16'd7);
    last_exp = cur_wide ? {tmr_b, tmr_a} : (cur_sel ? {16'h0, tmr_a} : {16'h0, tmr_b});
    if (cap) q.push_back(last_exp);
    pin = lvl;
    repeat (6) @(negedge clk);
  endtask

  task automatic settle(string tag);
    repeat (8) @(negedge clk);
    chk_eq({tag, " pending"}, q.size(), 0);
    chk_eq({tag, " not-empty"}, {31'd0, reg_rdata[0]}, 0);
  endtask

  task automatic pop1();
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
  endtask

  logic [31:0] vals [5];
  int i0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk_eq("R2 status reset", reg_rdata, 0);
    reg_addr = 1'b0; #1;
    chk_eq("R2 ctrl reset", reg_rdata, 0);
    reg_addr = 1'b1;
    chk_eq("R1 irq reset", {31'd0, irq}, 0);

    // R3 latency, monitor off
    cfg(cw(1, 3'b011, 0, 2'b00, 1, 0, 0));
    tmr_a = 16'd100; pin = 1'b1;
    for (int j = 1; j <= 3; j++) begin
      @(negedge clk);
      chk_eq($sformatf("R3 not-empty at edge %0d", j), {31'd0, reg_rdata[0]}, (j == 3) ? 1 : 0);
      if (j == 3) chk_eq("R3 stamped value", cap_data, 32'd102);
      tmr_a = 16'(100 + j);
    end
    pop1();
    chk_eq("R8 empty after pop", {31'd0, reg_rdata[0]}, 0);
    pin_to(0, 0);

    mon_on = 1'b1;
    // R4 rising only, timer A
    cfg(cw(1, 3'b011, 0, 2'b00, 1, 0, 0));
    for (int j = 0; j < 3; j++) begin pin_to(1, 1); pin_to(0, 0); end
    settle("R4 rise");
    // R4 falling only, timer B
    cfg(cw(1, 3'b010, 0, 2'b00, 0, 0, 0));
    for (int j = 0; j < 3; j++) begin pin_to(1, 0); pin_to(0, 1); end
    settle("R4 fall");
    // R4 every edge, R7 wide with sel ignored
    cfg(cw(1, 3'b001, 0, 2'b00, 1, 1, 0));
    for (int j = 0; j < 2; j++) begin pin_to(1, 1); pin_to(0, 1); end
    settle("R7 wide any");
    // R5 every 4th rise
    cfg(cw(1, 3'b100, 0, 2'b00, 1, 0, 0));
    for (int j = 0; j < 8; j++) begin pin_to(1, j == 3 || j == 7); pin_to(0, 0); end
    settle("R5 div4");
    // R5 every 16th rise
    cfg(cw(1, 3'b101, 0, 2'b00, 0, 0, 0));
    for (int j = 0; j < 16; j++) begin pin_to(1, j == 15); pin_to(0, 0); end
    settle("R5 div16");
    // R5 control write restarts the prescaler
    cfg(cw(1, 3'b100, 0, 2'b00, 1, 0, 0));
    for (int j = 0; j < 2; j++) begin pin_to(1, 0); pin_to(0, 0); end
    wr_ctrl(cw(1, 3'b100, 0, 2'b00, 1, 0, 0));
    for (int j = 0; j < 4; j++) begin pin_to(1, j == 3); pin_to(0, 0); end
    settle("R5 restart");
    // R6 alternate, first falling
    cfg(cw(1, 3'b110, 0, 2'b00, 1, 0, 0));
    pin_to(1, 0); pin_to(0, 1); pin_to(1, 1); pin_to(0, 1);
    settle("R6 alt fall-first");
    // R6 alternate, first rising
    cfg(cw(1, 3'b110, 1, 2'b00, 0, 0, 0));
    pin_to(1, 1); pin_to(0, 1); pin_to(1, 1); pin_to(0, 1);
    settle("R6 alt rise-first");
    // R6 off modes
    i0 = irq_n;
    cfg(cw(1, 3'b000, 0, 2'b00, 1, 0, 0));
    pin_to(1, 0); pin_to(0, 0);
    cfg(cw(1, 3'b111, 0, 2'b00, 1, 0, 0));
    pin_to(1, 0); pin_to(0, 0);
    settle("R6 off");
    chk_eq("R6 no irq when off", irq_n - i0, 0);

    // R11 idle halt
    cfg(cw(1, 3'b001, 0, 2'b00, 1, 0, 1));
    idle = 1'b1;
    pin_to(1, 0); pin_to(0, 0);
    settle("R11 halted");
    idle = 1'b0;
    pin_to(1, 1);
    settle("R11 resumed");
    cfg(cw(1, 3'b001, 0, 2'b00, 1, 0, 0));
    idle = 1'b1;
    pin_to(0, 1);
    settle("R11 run in idle");
    idle = 1'b0;

    // R10 interrupt divisors
    cfg(cw(1, 3'b001, 0, 2'b10, 1, 0, 0));
    i0 = irq_n;
    pin_to(~pin, 1); pin_to(~pin, 1);
    chk_eq("R10 div3 none at 2", irq_n - i0, 0);
    pin_to(~pin, 1);
    chk_eq("R10 div3 one at 3", irq_n - i0, 1);
    for (int j = 0; j < 3; j++) pin_to(~pin, 1);
    chk_eq("R10 div3 two at 6", irq_n - i0, 2);
    cfg(cw(1, 3'b001, 0, 2'b11, 1, 0, 0));
    i0 = irq_n;
    for (int j = 0; j < 8; j++) pin_to(~pin, 1);
    chk_eq("R10 div4", irq_n - i0, 2);
    cfg(cw(1, 3'b001, 0, 2'b00, 1, 0, 0));
    i0 = irq_n;
    for (int j = 0; j < 3; j++) pin_to(~pin, 1);
    chk_eq("R10 every", irq_n - i0, 3);
    cfg(cw(1, 3'b001, 0, 2'b01, 1, 0, 0));
    i0 = irq_n;
    for (int j = 0; j < 4; j++) pin_to(~pin, 1);
    chk_eq("R10 div2", irq_n - i0, 2);
    settle("R10");
    chk_eq("R10 single-cycle pulse", irq_wide, 0);

    // R8 R9 fill and overflow, monitor paused
    mon_on = 1'b0;
    cfg(cw(1, 3'b001, 0, 2'b00, 1, 0, 0));
    for (int j = 0; j < 5; j++) begin pin_to(~pin, 0); vals[j] = last_exp; end
    chk_eq("R9 full+ovf status", reg_rdata, 32'd3);
    chk_eq("R8 head oldest", cap_data, vals[0]);
    for (int j = 1; j < 4; j++) begin
      pop1();
      chk_eq($sformatf("R8 head after pop %0d", j), cap_data, vals[j]);
      chk_eq("R9 ovf kept", {31'd0, reg_rdata[1]}, 1);
    end
    pop1();
    chk_eq("R9 cleared when drained", reg_rdata, 0);

    // R1 disable flushes, counter cleared
    cfg(cw(1, 3'b001, 0, 2'b00, 1, 0, 0));
    for (int j = 0; j < 5; j++) pin_to(~pin, 0);
    chk_eq("R1 pre-disable status", reg_rdata, 32'd3);
    wr_ctrl(cw(0, 3'b001, 0, 2'b00, 1, 0, 0));
    @(negedge clk);
    chk_eq("R1 flushed", reg_rdata, 0);
    i0 = irq_n;
    pin_to(~pin, 0); pin_to(~pin, 0);
    chk_eq("R1 no irq disabled", irq_n - i0, 0);
    chk_eq("R1 no capture disabled", reg_rdata, 0);
    cfg(cw(1, 3'b001, 0, 2'b01, 1, 0, 0));
    i0 = irq_n;
    pin_to(~pin, 0);
    wr_ctrl(cw(0, 3'b001, 0, 2'b01, 1, 0, 0));
    wr_ctrl(cw(1, 3'b001, 0, 2'b01, 1, 0, 0));
    pin_to(~pin, 0);
    chk_eq("R1 irq count restarted", irq_n - i0, 0);
    pin_to(~pin, 0);
    chk_eq("R1 irq after two fresh", irq_n - i0, 1);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule